// File: doc/BRIEF.md
# IDE Bus-Master DMA FIFO Engine

This block is the data mover between two IDE disk ports and a host memory bus. Each port can be put into bus-master mode. While it is in that mode, the port's programmed-I/O chip selects are forced inactive, and data moves only when the device raises its DMA request. Both ports share one 64-byte FIFO, organised as 16 words of 32 bits. On the disk side the block pulses a per-port read strobe (device-to-memory) or write strobe (memory-to-device), one FIFO word per strobe. A strobe is paused whenever the FIFO cannot take or supply a word. On the memory side the block asks for fixed bursts of eight 32-bit words and moves one word per memory beat.

A round-robin arbiter decides which port owns the FIFO. Its states are ARB_IDLE, ARB_P0 and ARB_P1. The transitions are: GRANT (from idle to the requesting port, or to the port not served last when both request), SWITCH (to the other port) and RELEASE (back to idle). A port gives up the FIFO only when two things hold: the FIFO is empty with no memory burst open, and either its own request has dropped or it has moved eight words while the other port waits. The memory-burst controller has the states B_IDLE, B_REQ and B_DATA. Its transitions are START (idle to request), ACK (request to data) and LAST (data back to idle after the eighth beat). A device interrupt from a device-to-memory port is withheld until the FIFO is empty. For memory-to-device transfers the interrupt is passed on at once.

Top module: `ide_bm_fifo_engine`

## Requirements
- R1: After reset the FIFO is empty: `fifo_level`=0, `fifo_empty`=1, `fifo_full`=0. `fifo_level` counts stored 32-bit words (0..16), and `fifo_full` is 1 exactly when it is 16. No push happens while full and no pop happens while empty.
- R2: While `bm_en[p]`=1, `cs_n[p]` is 1. While `bm_en[p]`=0, `cs_n[p]` equals `pio_cs_n[p]`, and port p never strobes.
- R3: For a granted port with `xfer_d2m[p]`=1 (device-to-memory), `dior_n[p]` is 0 in each cycle where the port's request is high and the FIFO is not full. The word on `dev_rdata` is stored at that clock edge. While the FIFO is full, `dior_n` stays 1.
- R4: For a granted port with `xfer_d2m[p]`=0 (memory-to-device), `diow_n[p]` is 0 in each cycle where the request is high and the FIFO is not empty. The oldest word is on `dev_wdata` during the strobe and is removed at that edge.
- R5: With a device-to-memory port granted and at least 8 words stored, the block raises `burst_req` with `burst_wr`=1 until `burst_ack`. Each of the next 8 `mem_beat` cycles presents the oldest word on `mem_wdata` and removes it, in arrival order.
- R6: With a memory-to-device port granted and at least 8 words free, the block raises `burst_req` with `burst_wr`=0. Each of the next 8 `mem_beat` cycles stores `mem_rdata`.
- R7: From idle, port 0 is granted first after reset. When both ports request, the port not served last wins. The owner changes only when the FIFO is empty and no burst is open. With both ports streaming device-to-memory, the strobes alternate in runs of exactly 8 words: port 0, port 1, port 0, and so on.
- R8: `host_irq[p]` follows `dev_irq[p]`, except that for a bus-master device-to-memory port it stays 0 while the FIFO holds data.
- R9: At most one disk strobe (`dior_n` or `diow_n` of either port) is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bm_en | input | 2 | Bus-master enable per port |
| xfer_d2m | input | 2 | Per-port direction, 1 = device to memory |
| dev_dreq | input | 2 | Device DMA request per port |
| pio_cs_n | input | 2 | Programmed-I/O chip selects passed through when not bus-mastering |
| dev_rdata | input | 32 | Word read from the device |
| dev_wdata | output | 32 | Word written to the device |
| dior_n | output | 2 | Disk read strobe per port, active low |
| diow_n | output | 2 | Disk write strobe per port, active low |
| cs_n | output | 2 | Chip selects per port, active low |
| dev_irq | input | 2 | Device interrupt per port |
| host_irq | output | 2 | Interrupt forwarded to the host per port |
| burst_req | output | 1 | Memory burst request |
| burst_wr | output | 1 | Burst direction, 1 = write to memory |
| burst_ack | input | 1 | Memory accepts the burst |
| mem_beat | input | 1 | One data word moves this cycle |
| mem_rdata | input | 32 | Word read from memory |
| mem_wdata | output | 32 | Word written to memory |
| fifo_level | output | 5 | Stored words |
| fifo_full | output | 1 | FIFO full flag |
| fifo_empty | output | 1 | FIFO empty flag |

## Verification
A wrong FIFO pointer or count shows up at the next memory beat or disk write strobe: the word seen there differs from the one the scoreboard queued, so the error appears within one burst of eight beats. A wrong arbiter state shows up as a run of strobes from one port that is not eight long, or a strobe from the wrong port, visible in the first strobe after the faulty switch. A wrong empty flag shows up as an interrupt that comes too early or never comes. It also shows up as a transfer that stalls, and the bench catches that when the FIFO fails to drain.

// File: rtl/ide_bm_pkg.sv
package ide_bm_pkg;
    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,
        ARB_P0   = 2'd1,
        ARB_P1   = 2'd2
    } arb_state_e;

    typedef enum logic [1:0] {
        B_IDLE = 2'd0,
        B_REQ  = 2'd1,
        B_DATA = 2'd2
    } bst_state_e;
endpackage

// File: rtl/bm_fifo.sv
module bm_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [DW-1:0]                wdata,
    input  logic                         pop,
    output logic [DW-1:0]                rdata,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [DW-1:0] store [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt_nx;

    always_comb begin
        cnt_nx = level;
        if (push && !pop)      cnt_nx = level + CW'(1);
        else if (pop && !push) cnt_nx = level - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
            full  <= 1'b0;
            empty <= 1'b1;
        end else begin
            if (push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + AW'(1);
            if (pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + AW'(1);
            level <= cnt_nx;
            full  <= (cnt_nx == CW'(DEPTH));
            empty <= (cnt_nx == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (push) store[wp] <= wdata;
    end

    assign rdata = store[rp];

    p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push || pop);
    p_no_underflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);
endmodule

// File: rtl/bm_arbiter.sv
module bm_arbiter
    import ide_bm_pkg::*;
#(
    parameter int BURST = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req,
    input  logic       stb,
    input  logic       can_sw,
    output logic       gnt_vld,
    output logic       gnt,
    output logic       xfer_ok
);
    localparam int BCW = $clog2(BURST);

    arb_state_e st, st_nx;
    logic           last;
    logic [BCW-1:0] wcnt;
    logic           bdone;
    logic           own_req, oth_req;

    always_comb begin
        st_nx = st;
        unique case (st)
            ARB_IDLE: begin
                if (req == 2'b11)  st_nx = last ? ARB_P0 : ARB_P1;  // GRANT
                else if (req[0])   st_nx = ARB_P0;
                else if (req[1])   st_nx = ARB_P1;
            end
            ARB_P0: if (can_sw && (!req[0] || (bdone && req[1])))
                        st_nx = req[1] ? ARB_P1 : ARB_IDLE;          // SWITCH / RELEASE
            ARB_P1: if (can_sw && (!req[1] || (bdone && req[0])))
                        st_nx = req[0] ? ARB_P0 : ARB_IDLE;
            default: st_nx = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= ARB_IDLE;
            last  <= 1'b1;
            wcnt  <= '0;
            bdone <= 1'b0;
        end else begin
            st <= st_nx;
            if (st_nx == ARB_P0 && st != ARB_P0) last <= 1'b0;
            if (st_nx == ARB_P1 && st != ARB_P1) last <= 1'b1;
            if (st_nx != st) begin
                wcnt  <= '0;
                bdone <= 1'b0;
            end else if (stb) begin
                if (wcnt == BCW'(BURST-1)) begin
                    wcnt  <= '0;
                    bdone <= 1'b1;
                end else begin
                    wcnt  <= wcnt + BCW'(1);
                    bdone <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        gnt_vld = (st != ARB_IDLE);
        gnt     = (st == ARB_P1);
        own_req = req[gnt];
        oth_req = req[!gnt];
        xfer_ok = gnt_vld && own_req && !(bdone && oth_req);
    end

    p_switch_when_drained_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_vld && $past(gnt_vld) && (gnt != $past(gnt))) |-> $past(can_sw));
endmodule

// File: rtl/bm_burst.sv
module bm_burst
    import ide_bm_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int BURST = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        gnt_vld,
    input  logic                        gnt_d2m,
    input  logic [$clog2(DEPTH+1)-1:0]  level,
    input  logic                        burst_ack,
    input  logic                        mem_beat,
    output logic                        burst_req,
    output logic                        burst_wr,
    output logic                        in_data,
    output logic                        idle
);
    localparam int LW  = $clog2(DEPTH+1);
    localparam int BCW = $clog2(BURST);

    bst_state_e     st, st_nx;
    logic [BCW-1:0] bcnt;
    logic           want_wr, want_rd;

    assign want_wr = gnt_vld && gnt_d2m && (level >= LW'(BURST));
    assign want_rd = gnt_vld && !gnt_d2m && (level <= LW'(DEPTH-BURST));

    always_comb begin
        st_nx = st;
        unique case (st)
            B_IDLE: if (want_wr || want_rd) st_nx = B_REQ;                         // START
            B_REQ:  if (burst_ack) st_nx = B_DATA;                                  // ACK
            B_DATA: if (mem_beat && bcnt == BCW'(BURST-1)) st_nx = B_IDLE;          // LAST
            default: st_nx = B_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= B_IDLE;
            bcnt     <= '0;
            burst_wr <= 1'b0;
        end else begin
            st <= st_nx;
            if (st == B_IDLE && st_nx == B_REQ) burst_wr <= want_wr;
            if (st != B_DATA)    bcnt <= '0;
            else if (mem_beat)   bcnt <= bcnt + BCW'(1);
        end
    end

    always_comb begin
        burst_req = (st == B_REQ);
        in_data   = (st == B_DATA);
        idle      = (st == B_IDLE);
    end

    p_wr_burst_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(burst_req) && burst_wr) |-> (level >= LW'(BURST)));
    p_rd_burst_space_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(burst_req) && !burst_wr) |-> (level <= LW'(DEPTH-BURST)));
endmodule

// File: rtl/ide_bm_fifo_engine.sv
module ide_bm_fifo_engine #(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    parameter int BURST = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [1:0]                  bm_en,
    input  logic [1:0]                  xfer_d2m,
    input  logic [1:0]                  dev_dreq,
    input  logic [1:0]                  pio_cs_n,
    input  logic [DW-1:0]               dev_rdata,
    output logic [DW-1:0]               dev_wdata,
    output logic [1:0]                  dior_n,
    output logic [1:0]                  diow_n,
    output logic [1:0]                  cs_n,
    input  logic [1:0]                  dev_irq,
    output logic [1:0]                  host_irq,
    output logic                        burst_req,
    output logic                        burst_wr,
    input  logic                        burst_ack,
    input  logic                        mem_beat,
    input  logic [DW-1:0]               mem_rdata,
    output logic [DW-1:0]               mem_wdata,
    output logic [$clog2(DEPTH+1)-1:0]  fifo_level,
    output logic                        fifo_full,
    output logic                        fifo_empty
);
    logic [1:0]    req;
    logic          gnt_vld, gnt, xfer_ok, gdir;
    logic          rd_stb, wr_stb;
    logic          bst_data, bst_idle, can_sw;
    logic          push, pop;
    logic [DW-1:0] fifo_wd, fifo_rd;

    assign req    = bm_en & dev_dreq;
    assign gdir   = xfer_d2m[gnt];
    assign rd_stb = xfer_ok && gdir && !fifo_full;
    assign wr_stb = xfer_ok && !gdir && !fifo_empty;
    assign can_sw = fifo_empty && bst_idle;
    assign push   = rd_stb || (bst_data && mem_beat && !burst_wr);
    assign pop    = wr_stb || (bst_data && mem_beat && burst_wr);
    assign fifo_wd = rd_stb ? dev_rdata : mem_rdata;
    assign dev_wdata = fifo_rd;
    assign mem_wdata = fifo_rd;

    bm_arbiter #(.BURST(BURST)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(req), .stb(rd_stb || wr_stb),
        .can_sw(can_sw), .gnt_vld(gnt_vld), .gnt(gnt), .xfer_ok(xfer_ok)
    );

    bm_burst #(.DEPTH(DEPTH), .BURST(BURST)) u_bst (
        .clk(clk), .rst_n(rst_n), .gnt_vld(gnt_vld), .gnt_d2m(gdir),
        .level(fifo_level), .burst_ack(burst_ack), .mem_beat(mem_beat),
        .burst_req(burst_req), .burst_wr(burst_wr), .in_data(bst_data), .idle(bst_idle)
    );

    bm_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .wdata(fifo_wd), .pop(pop),
        .rdata(fifo_rd), .level(fifo_level), .full(fifo_full), .empty(fifo_empty)
    );

    for (genvar p = 0; p < 2; p++) begin : g_port
        assign dior_n[p]   = !(rd_stb && (gnt == 1'(p)));
        assign diow_n[p]   = !(wr_stb && (gnt == 1'(p)));
        assign cs_n[p]     = bm_en[p] ? 1'b1 : pio_cs_n[p];
        assign host_irq[p] = dev_irq[p] && !(bm_en[p] && xfer_d2m[p] && !fifo_empty);

        p_rd_pause_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !dior_n[p] |-> !fifo_full && bm_en[p] && xfer_d2m[p]);
        p_wr_pause_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !diow_n[p] |-> !fifo_empty && bm_en[p] && !xfer_d2m[p]);
    end

    p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~dior_n, ~diow_n}) <= 1);
endmodule

// File: tb/sim_ide_bm_fifo_engine.sv
module sim_ide_bm_fifo_engine;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bm_en = '0, xfer_d2m = '0, dev_dreq = '0, pio_cs_n = 2'b01, dev_irq = '0;
    logic [31:0] dev_rdata = 32'h1000_0000;
    logic [31:0] dev_wdata, mem_wdata;
    logic [31:0] mem_rdata = 32'h0;
    logic [1:0]  dior_n, diow_n, cs_n, host_irq;
    logic        burst_req, burst_wr, fifo_full, fifo_empty;
    logic        burst_ack = 1'b0, mem_beat = 1'b0;
    logic [4:0]  fifo_level;

    int errors = 0, checks = 0;
    logic [31:0] expq[$];
    int   port_seq[$];
    int   nstb = 0, ncmp = 0, overlap = 0;
    bit   mem_hold = 1'b0;
    bit   exp_wr = 1'b1;
    logic [31:0] mword = 32'hA000_0000;

    always #(CLK_PERIOD/2) clk = ~clk;

    ide_bm_fifo_engine u0 (
        .clk(clk), .rst_n(rst_n), .bm_en(bm_en), .xfer_d2m(xfer_d2m), .dev_dreq(dev_dreq),
        .pio_cs_n(pio_cs_n), .dev_rdata(dev_rdata), .dev_wdata(dev_wdata), .dior_n(dior_n),
        .diow_n(diow_n), .cs_n(cs_n), .dev_irq(dev_irq), .host_irq(host_irq),
        .burst_req(burst_req), .burst_wr(burst_wr), .burst_ack(burst_ack), .mem_beat(mem_beat),
        .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .fifo_level(fifo_level),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // next device word advances after each captured read strobe
    always @(posedge clk) if (dior_n != 2'b11) dev_rdata <= dev_rdata + 32'h0101_0101;

    // disk-side driver record and monitor
    always @(negedge clk) begin
        if ($countones({~dior_n, ~diow_n}) > 1) overlap++;
        for (int p = 0; p < 2; p++) begin
            if (!dior_n[p]) begin
                expq.push_back(dev_rdata);
                port_seq.push_back(p);
                nstb++;
            end
            if (!diow_n[p]) begin
                if (expq.size() == 0) chk(1'b0, "R4 unexpected write strobe", dev_wdata, 32'h0);
                else begin
                    logic [31:0] e;
                    e = expq.pop_front();
                    chk(dev_wdata == e, "R4 device write data", dev_wdata, e);
                end
                ncmp++;
            end
        end
    end

    // memory responder
    initial begin
        forever begin
            @(negedge clk);
            if (burst_req && !mem_hold) begin
                bit wr;
                wr = burst_wr;
                chk(wr == exp_wr, "R5 R6 burst direction", 32'(wr), 32'(exp_wr));
                burst_ack = 1'b1;
                @(negedge clk);
                burst_ack = 1'b0;
                for (int i = 0; i < 8; i++) begin
                    mem_beat = 1'b1;
                    if (wr) begin
                        if (expq.size() == 0) chk(1'b0, "R5 beat with no data", mem_wdata, 32'h0);
                        else begin
                            logic [31:0] e;
                            e = expq.pop_front();
                            chk(mem_wdata == e, "R5 memory write data", mem_wdata, e);
                        end
                    end else begin
                        mem_rdata = mword;
                        expq.push_back(mword);
                        mword = mword + 32'h11;
                    end
                    @(negedge clk);
                end
                mem_beat = 1'b0;
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        bm_en = '0; xfer_d2m = '0; dev_dreq = '0; dev_irq = '0;
        repeat (3) @(posedge clk);
        expq.delete();
        port_seq.delete();
        nstb = 0; ncmp = 0; overlap = 0;
        #1 rst_n = 1'b1;
    endtask

    task automatic wait_drained(input string rq);
        int n = 0;
        while (!(fifo_empty && expq.size() == 0) && n < 400) begin
            @(negedge clk);
            n++;
        end
        chk(fifo_empty && expq.size() == 0, rq, 32'(expq.size()), 32'h0);
    endtask

    task automatic run_tests();
        // R1, R2: reset state
        do_reset();
        @(negedge clk);
        chk(fifo_level == 0, "R1 reset level", 32'(fifo_level), 0);
        chk(fifo_empty && !fifo_full, "R1 reset flags", {30'h0, fifo_full, fifo_empty}, 32'h1);
        chk(cs_n == 2'b01, "R2 pio chip select pass-through", 32'(cs_n), 32'h1);
        chk(dior_n == 2'b11 && diow_n == 2'b11 && !burst_req, "R2 idle outputs",
            {26'h0, burst_req, 1'b0, dior_n, diow_n} , 32'h0F);

        // R2: enable forces chip select high; no strobe without enable
        pio_cs_n = 2'b00;
        bm_en = 2'b01;
        dev_dreq = 2'b10;
        xfer_d2m = 2'b11;
        repeat (4) @(negedge clk);
        chk(cs_n == 2'b01, "R2 bus-master chip select", 32'(cs_n), 32'h1);
        chk(dior_n == 2'b11 && nstb == 0, "R2 disabled port silent", 32'(nstb), 0);

        // R3, R5: single device-to-memory stream, 32 words
        do_reset();
        exp_wr = 1'b1;
        bm_en = 2'b01; xfer_d2m = 2'b01; dev_dreq = 2'b01;
        do @(posedge clk); while (nstb < 32);
        #1 dev_dreq = 2'b00;
        wait_drained("R3 R5 stream drained");
        chk(nstb == 32, "R3 strobe count", 32'(nstb), 32);

        // R3 pause when full, R8 interrupt deferral
        do_reset();
        mem_hold = 1'b1;
        bm_en = 2'b01; xfer_d2m = 2'b01; dev_dreq = 2'b01;
        repeat (30) @(negedge clk);
        chk(fifo_full && fifo_level == 16, "R1 full at 16 words", 32'(fifo_level), 16);
        chk(dior_n == 2'b11, "R3 read strobe paused when full", 32'(dior_n), 32'h3);
        chk(nstb == 16, "R3 no strobe past full", 32'(nstb), 16);
        @(posedge clk); #1 dev_dreq = 2'b00; dev_irq = 2'b01;
        @(negedge clk);
        chk(host_irq[0] == 1'b0, "R8 interrupt withheld", 32'(host_irq), 0);
        mem_hold = 1'b0;
        wait_drained("R5 held data drained");
        @(negedge clk);
        chk(host_irq[0] == 1'b1, "R8 interrupt after drain", 32'(host_irq), 1);
        dev_irq = 2'b00;

        // R7, R9: both ports device-to-memory
        do_reset();
        bm_en = 2'b11; xfer_d2m = 2'b11; dev_dreq = 2'b11;
        do @(posedge clk); while (nstb < 48);
        #1 dev_dreq = 2'b00;
        wait_drained("R7 shared stream drained");
        begin
            int bad = 0;
            for (int i = 0; i < port_seq.size(); i++)
                if (port_seq[i] != ((i / 8) % 2)) bad++;
            chk(bad == 0 && port_seq.size() == 48, "R7 round-robin runs of 8", 32'(bad), 0);
        end
        chk(overlap == 0, "R9 single active strobe", 32'(overlap), 0);

        // R6, R4, R8: memory-to-device on port 1
        do_reset();
        exp_wr = 1'b0;
        bm_en = 2'b10; xfer_d2m = 2'b00; dev_irq = 2'b10;
        @(negedge clk);
        chk(host_irq == 2'b10, "R8 immediate interrupt memory-to-device", 32'(host_irq), 32'h2);
        dev_irq = 2'b00;
        dev_dreq = 2'b10;
        do @(posedge clk); while (ncmp < 24);
        #1 dev_dreq = 2'b00;
        repeat (20) @(negedge clk);
        chk(ncmp == 24, "R6 R4 words delivered", 32'(ncmp), 24);
        chk(overlap == 0, "R9 single active strobe", 32'(overlap), 0);
        do_reset();
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (100000) @(posedge clk);
                chk(1'b0, "watchdog", 0, 1);
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule